// File: doc/BRIEF.md
# Flash Event Interrupt Status Register

This block is an 8-bit control and status register that sits between a flash sequencer and the CPU bus. It keeps four event flags: program finished, program timed out, erase finished and erase timed out. Each flag has its own interrupt enable. The sequencer raises a flag with a one-cycle pulse. Software clears a flag only by writing 0 to its bit. A single registered interrupt line goes high while any enabled flag is set.

Software clears flags with read-modify-write bit operations. A read tagged as read-modify-write therefore returns 1 in every flag position. When that value is written back, the flags see 1s, which leave them untouched, so pending flags survive a bit operation aimed at a neighbouring enable.

Software may also clear the program-finished flag while it is set. After that, the block holds a command-lock output high toward the sequencer, which blocks further program and erase commands. The lock is released by a reset-command pulse.

Top module: `flash_evt_status_reg`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all eight register bits are 0, and `irq_o`, `cmd_lock_o` and `bus_rd_data` are 0.
- R2: Register layout, from bit 7 down to bit 0: program-done enable, program-done flag, program-timeout enable, program-timeout flag, erase-done enable, erase-done flag, erase-timeout enable, erase-timeout flag. A bus write loads the four enable bits (7, 5, 3, 1) directly from the written data.
- R3: A one-cycle pulse on `seq_pgm_done`, `seq_pgm_tmo`, `seq_ers_done` or `seq_ers_tmo` sets the matching flag (bit 6, 4, 2 or 0) at that clock edge.
- R4: On a bus write, a 0 in a flag position clears that flag, and a 1 in a flag position leaves it unchanged.
- R5: If a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: A `seq_pgm_fail` pulse forces the program-done flag (bit 6) to 0. This overrides a program-done pulse in the same cycle.
- R7: A read with `bus_rd_rmw` high returns 1 in bits 6, 4, 2 and 0 and the true enable values in bits 7, 5, 3 and 1. A read with `bus_rd_rmw` low returns the true value of all bits.
- R8: `irq_o` is registered. It is 1 in the cycle after any flag is 1 while its enable is 1, and 0 in the cycle after no such pair exists.
- R9: A bus write of 0 to bit 6 while the program-done flag is 1, with no program-done pulse in the same cycle, sets `cmd_lock_o` at that edge. A `seq_reset_cmd` pulse clears `cmd_lock_o`, unless a lock-setting write happens in the same cycle, in which case the lock stays set. Clearing bit 6 while it is already 0 does not set the lock.
- R10: `bus_rd_data` is registered. It is loaded at the edge where `bus_rd_en` is high and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_data | input | 8 | Write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rd_rmw | input | 1 | Marks the read as part of a read-modify-write |
| bus_rd_data | output | 8 | Registered read data |
| seq_pgm_done | input | 1 | Pulse: program algorithm finished |
| seq_pgm_fail | input | 1 | Pulse: program failed |
| seq_pgm_tmo | input | 1 | Pulse: program timed out |
| seq_ers_done | input | 1 | Pulse: erase algorithm finished |
| seq_ers_tmo | input | 1 | Pulse: erase timed out |
| seq_reset_cmd | input | 1 | Pulse: reset command received |
| irq_o | output | 1 | Combined interrupt request, registered |
| cmd_lock_o | output | 1 | Blocks new program and erase commands |

## Verification
The assertions assume that sequencer events are single-cycle pulses sampled at a clock edge. They also assume that a read strobe and a write strobe may share a cycle, in which case the read returns the value from before the write. The stimulus raises every pulse and strobe for exactly one cycle, driven on the falling edge. The same-cycle collisions (set against clear, fail against done, reset command against lock-setting write) are the only overlaps it creates on purpose, and each appears in a directed step.

// File: rtl/flash_evt_pkg.sv
package flash_evt_pkg;
  localparam int NUM_EVT = 4;
  localparam int REG_W   = 2 * NUM_EVT;

  // pair index k occupies bits {2k+1 enable, 2k flag}
  localparam int EV_ERS_TMO = 0;
  localparam int EV_ERS_DONE = 1;
  localparam int EV_PGM_TMO = 2;
  localparam int EV_PGM_DONE = 3;

  function automatic logic [REG_W-1:0] flag_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_EVT; k++) m[2*k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/flash_evt_flag.sv
module flash_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic kill_i,
  input  logic wr_i,
  input  logic wen_bit_i,
  input  logic wflag_bit_i,
  output logic en_o,
  output logic flag_o
);
  logic en_q, flag_q;
  logic clr_req;

  assign clr_req = wr_i && !wflag_bit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) en_q <= wen_bit_i;
      if (kill_i)       flag_q <= 1'b0;
      else if (set_i)   flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (set_i && !kill_i) |=> flag_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_i) |=> !flag_o);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !kill_i && !clr_req) |=> (flag_o == $past(flag_o)));
  p_kill_r6: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> !flag_o);
  p_enable_r2: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (en_o == $past(wen_bit_i)));
endmodule

// File: rtl/flash_irq_merge.sv
module flash_irq_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] live;
  logic         irq_q;

  assign live = flag_i & en_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |live;
  end

  assign irq_o = irq_q;

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (|(flag_i & en_i)) |=> irq_o);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/flash_cmd_lock.sv
module flash_cmd_lock (
  input  logic clk,
  input  logic rst,
  input  logic sw_clr_i,
  input  logic flag_i,
  input  logic set_evt_i,
  input  logic reset_cmd_i,
  output logic lock_o
);
  logic arm, lock_q;

  assign arm = sw_clr_i && flag_i && !set_evt_i;

  always_ff @(posedge clk) begin
    if (rst)              lock_q <= 1'b0;
    else if (arm)         lock_q <= 1'b1;
    else if (reset_cmd_i) lock_q <= 1'b0;
  end

  assign lock_o = lock_q;

  p_lock_set_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_clr_i && flag_i && !set_evt_i) |=> lock_o);
  p_lock_release_r9: assert property (@(posedge clk) disable iff (rst)
    (reset_cmd_i && !(sw_clr_i && flag_i && !set_evt_i)) |=> !lock_o);
  p_lock_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!reset_cmd_i && !sw_clr_i) |=> (lock_o == $past(lock_o)));
endmodule

// File: rtl/flash_evt_status_reg.sv
module flash_evt_status_reg
  import flash_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic [REG_W-1:0] bus_wr_data,
  input  logic             bus_rd_en,
  input  logic             bus_rd_rmw,
  output logic [REG_W-1:0] bus_rd_data,
  input  logic             seq_pgm_done,
  input  logic             seq_pgm_fail,
  input  logic             seq_pgm_tmo,
  input  logic             seq_ers_done,
  input  logic             seq_ers_tmo,
  input  logic             seq_reset_cmd,
  output logic             irq_o,
  output logic             cmd_lock_o
);
  localparam logic [REG_W-1:0] FMASK = flag_mask();

  logic [NUM_EVT-1:0] set_v, kill_v, en_v, flag_v;
  logic [REG_W-1:0]   view, rd_q;

  always_comb begin
    set_v = '0;
    set_v[EV_ERS_TMO]  = seq_ers_tmo;
    set_v[EV_ERS_DONE] = seq_ers_done;
    set_v[EV_PGM_TMO]  = seq_pgm_tmo;
    set_v[EV_PGM_DONE] = seq_pgm_done;
    kill_v = '0;
    kill_v[EV_PGM_DONE] = seq_pgm_fail;
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_pair
    flash_evt_flag u_flag (
      .clk         (clk),
      .rst         (rst),
      .set_i       (set_v[k]),
      .kill_i      (kill_v[k]),
      .wr_i        (bus_wr_en),
      .wen_bit_i   (bus_wr_data[2*k+1]),
      .wflag_bit_i (bus_wr_data[2*k]),
      .en_o        (en_v[k]),
      .flag_o      (flag_v[k])
    );
    assign view[2*k+1] = en_v[k];
    assign view[2*k]   = flag_v[k];
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_q <= '0;
    else if (bus_rd_en) rd_q <= bus_rd_rmw ? (view | FMASK) : view;
  end

  assign bus_rd_data = rd_q;

  flash_irq_merge #(.N(NUM_EVT)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flag_i (flag_v),
    .en_i   (en_v),
    .irq_o  (irq_o)
  );

  flash_cmd_lock u_lock (
    .clk         (clk),
    .rst         (rst),
    .sw_clr_i    (bus_wr_en && !bus_wr_data[2*EV_PGM_DONE]),
    .flag_i      (flag_v[EV_PGM_DONE]),
    .set_evt_i   (seq_pgm_done),
    .reset_cmd_i (seq_reset_cmd),
    .lock_o      (cmd_lock_o)
  );

  p_rmw_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_rd_rmw) |=> ((bus_rd_data & FMASK) == FMASK));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rd_data));
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (bus_rd_data == '0 && !irq_o && !cmd_lock_o));
endmodule

// File: tb/flash_evt_status_reg_tb_top.sv
module flash_evt_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, rd_rmw = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic p_done = 0, p_fail = 0, p_tmo = 0, e_done = 0, e_tmo = 0, rcmd = 0;
  logic irq, lock;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_evt_status_reg dut_i (
    .clk(clk), .rst(rst),
    .bus_wr_en(wr_en), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_rmw(rd_rmw), .bus_rd_data(rd_data),
    .seq_pgm_done(p_done), .seq_pgm_fail(p_fail), .seq_pgm_tmo(p_tmo),
    .seq_ers_done(e_done), .seq_ers_tmo(e_tmo), .seq_reset_cmd(rcmd),
    .irq_o(irq), .cmd_lock_o(lock)
  );

  // {wr, wdata[7:0], ev[4:0]={pgm_done,pgm_fail,pgm_tmo,ers_done,ers_tmo}, rcmd, exp_rd[7:0], exp_irq, exp_lock}
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'hAA, 5'b00000, 1'b0, 8'hAA, 1'b0, 1'b0}, // R2 enables load
    {1'b0, 8'h00, 5'b10000, 1'b0, 8'hEA, 1'b1, 1'b0}, // R3 program done
    {1'b1, 8'hFF, 5'b00000, 1'b0, 8'hEA, 1'b1, 1'b0}, // R4 write 1 ignored
    {1'b0, 8'h00, 5'b00001, 1'b0, 8'hEB, 1'b1, 1'b0}, // R3 erase timeout
    {1'b1, 8'hBF, 5'b00000, 1'b0, 8'hAB, 1'b1, 1'b1}, // R9 clear sets lock
    {1'b1, 8'hAA, 5'b00000, 1'b0, 8'hAA, 1'b0, 1'b1}, // R4 clear, R8 irq drops
    {1'b0, 8'h00, 5'b00000, 1'b1, 8'hAA, 1'b0, 1'b0}, // R9 release
    {1'b1, 8'hAA, 5'b00100, 1'b0, 8'hBA, 1'b1, 1'b0}, // R5 set beats clear
    {1'b0, 8'h00, 5'b11000, 1'b0, 8'hBA, 1'b1, 1'b0}, // R6 fail beats done
    {1'b1, 8'h00, 5'b00000, 1'b0, 8'h00, 1'b0, 1'b0}, // R9 no lock when flag 0
    {1'b0, 8'h00, 5'b00010, 1'b0, 8'h04, 1'b0, 1'b0}, // R8 disabled flag no irq
    {1'b1, 8'h0C, 5'b00000, 1'b0, 8'h0C, 1'b1, 1'b0}, // R8 enable raises irq
    {1'b0, 8'h00, 5'b10000, 1'b0, 8'h4C, 1'b1, 1'b0}, // R3
    {1'b1, 8'h0C, 5'b00000, 1'b0, 8'h0C, 1'b1, 1'b1}, // R9
    {1'b0, 8'h00, 5'b00000, 1'b1, 8'h0C, 1'b1, 1'b0}  // R9
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = 0; rd_en = 0; rd_rmw = 0;
    {p_done, p_fail, p_tmo, e_done, e_tmo, rcmd} = '0;
  endtask

  task automatic normal_read();
    rd_en = 1; rd_rmw = 0;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 lock", {7'b0, lock}, 8'h00);
    normal_read();
    chk("R1 register", rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i][24]; wr_data = VEC[i][23:16];
      {p_done, p_fail, p_tmo, e_done, e_tmo} = VEC[i][15:11];
      rcmd = VEC[i][10];
      @(negedge clk);
      idle();
      normal_read();
      chk($sformatf("vec%0d R2/R3/R4 rd", i), rd_data, VEC[i][9:2]);
      chk($sformatf("vec%0d R8 irq", i), {7'b0, irq}, {7'b0, VEC[i][1]});
      chk($sformatf("vec%0d R9 lock", i), {7'b0, lock}, {7'b0, VEC[i][0]});
    end

    // R7: rmw read shows flags as 1, enables true; state untouched
    rd_en = 1; rd_rmw = 1;
    @(negedge clk); idle();
    chk("R7 rmw read", rd_data, 8'h5D);
    normal_read();
    chk("R7 normal read after rmw", rd_data, 8'h0C);

    // R10: read data holds without a read strobe
    e_tmo = 1;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R10 hold", rd_data, 8'h0C);
    normal_read();
    chk("R10 reload", rd_data, 8'h0D);

    // R8: one-cycle registered delay of irq
    wr_en = 1; wr_data = 8'h80;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R8 irq low", {7'b0, irq}, 8'h00);
    p_done = 1;
    @(negedge clk); idle();
    chk("R8 irq not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 irq raised", {7'b0, irq}, 8'h01);

    // R9: reset command and lock-setting write in the same cycle
    wr_en = 1; wr_data = 8'h80; rcmd = 1;
    @(negedge clk); idle();
    chk("R9 lock wins", {7'b0, lock}, 8'h01);
    rcmd = 1;
    @(negedge clk); idle();
    chk("R9 release", {7'b0, lock}, 8'h00);

    // R6: fail alone clears a set program-done flag, no lock
    p_done = 1;
    @(negedge clk); idle();
    p_fail = 1;
    @(negedge clk); idle();
    normal_read();
    chk("R6 fail clears", rd_data, 8'h80);
    chk("R6 no lock", {7'b0, lock}, 8'h00);

    // R1: reset in mid-run
    p_done = 1;
    @(negedge clk); idle();
    normal_read();
    chk("R1 pre-reset", rd_data, 8'hC0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 rd cleared", rd_data, 8'h00);
    @(negedge clk);
    chk("R1 irq cleared", {7'b0, irq}, 8'h00);
    normal_read();
    chk("R1 reg cleared", rd_data, 8'h00);

    finish_run();
  end
endmodule